// File: doc/BRIEF.md
# Processor State Sequencer with Exception Entry

This block is the top-level state sequencer of a small 32-bit CPU core. It keeps the core in one of five states: reset, exception entry, program execution, power-down (a light sleep or a deep standby) and bus handover. Two active-low reset pins pick how much of the chip gets reset. When the core leaves reset, the block redirects the program counter to a fixed start address. When the core takes a general exception or an interrupt, the block stores the live program counter and status word in shadow registers and redirects fetch to the vector base plus the offset of the event.

The instruction datapath, interrupt prioritisation, the bus timing and the detailed wake rules sit outside this block. They reach it only as request levels and as the PC, SR, vector base and offset values. The block answers with a one-cycle redirect pulse, the saved context, a bus grant, run, sleep and standby flags, and two reset-scope enables. One enable goes to the general on-chip module registers. The other goes only to the bus controller registers.

Top module: `cpu_state_ctl`

## Requirements
- R1: While `por_n` is low, `state_o` is 0 (reset) and both `rst_mod_en_o` and `rst_busctl_en_o` are high. `spc_o`, `ssr_o` and `pc_load_o` are zero.
- R2: If `mrst_n` is low at a clock edge while `por_n` is high, then after that edge `state_o` is 0, `rst_mod_en_o` is 1, `rst_busctl_en_o` is 0, and the saved context is cleared.
- R3: When both reset pins are low together, the power-on scope wins: `rst_busctl_en_o` stays high.
- R4: At the first edge where both reset pins are high in the reset state, the block moves to execution (`state_o` = 2). For exactly that one cycle, `pc_load_o` is 1 and `pc_target_o` is 0xA0000000.
- R5: If `exc_req_i` or `irq_req_i` is high at an edge in execution, then after that edge `state_o` is 1. `spc_o` and `ssr_o` then hold the `pc_i` and `sr_i` values sampled at that edge, `pc_load_o` is 1, and `pc_target_o` is `vbr_i` plus the zero-extended `vec_ofs_i` sampled at that edge.
- R6: Exception entry lasts exactly one cycle. The next edge returns the block to execution and drops `pc_load_o`, whatever the requests are.
- R7: At an edge in execution, the priority order is: exception or interrupt, then `bus_req_i`, then `sleep_cmd_i`, then `standby_cmd_i`.
- R8: A bus request taken in execution moves the block to state 4 with `bus_gnt_o` high. The block stays there while `bus_req_i` is high. It returns to execution at the first edge where `bus_req_i` is low.
- R9: In sleep (state 3, `sleep_o` high), an interrupt request wakes the block into exception entry and saves context as in R5. An exception request and all other requests are ignored.
- R10: In standby (state 3, `standby_o` high), every request is ignored. Only a reset leaves standby.
- R11: `cpu_run_o` is high only in execution. The saved PC and SR change only on an accepted event or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, sampled on the clock |
| exc_req_i | input | 1 | General exception request |
| irq_req_i | input | 1 | Interrupt request |
| vec_ofs_i | input | OFS_W | Vector offset of the pending event |
| vbr_i | input | XLEN | Vector base value |
| pc_i | input | XLEN | Current program counter |
| sr_i | input | SR_W | Current status word |
| bus_req_i | input | 1 | External bus request |
| sleep_cmd_i | input | 1 | Enter sleep command |
| standby_cmd_i | input | 1 | Enter standby command |
| state_o | output | 3 | State: 0 reset, 1 exception entry, 2 execution, 3 power-down, 4 bus handover |
| pc_load_o | output | 1 | One-cycle fetch redirect strobe |
| pc_target_o | output | XLEN | Redirect target address |
| spc_o | output | XLEN | Saved program counter |
| ssr_o | output | SR_W | Saved status word |
| bus_gnt_o | output | 1 | Bus granted to the external requester |
| cpu_run_o | output | 1 | Instruction execution enabled |
| sleep_o | output | 1 | In sleep |
| standby_o | output | 1 | In standby |
| rst_mod_en_o | output | 1 | Reset enable for on-chip module registers |
| rst_busctl_en_o | output | 1 | Reset enable for bus controller registers |

## Verification
The hardest case to reach is a power-down state that receives competing requests. Reaching it takes a path through execution with a command, and while the block sits in standby the only way out is a reset. Directed sequences drive the block into sleep and into standby, then present each request alone. Random traffic follows, with sparse resets, so that standby and bus handover get entered and left many times with overlapping requests.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic [2:0] {
      CPS_RESET  = 3'd0,
      CPS_EXC    = 3'd1,
      CPS_RUN    = 3'd2,
      CPS_PDOWN  = 3'd3,
      CPS_BUSREL = 3'd4
   } cps_state_e;

   typedef enum logic {
      PD_SLEEP   = 1'b0,
      PD_STANDBY = 1'b1
   } pd_mode_e;
endpackage

// File: rtl/cps_seq.sv
module cps_seq
   import cps_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       mrst_n,
   input  logic       exc_req_i,
   input  logic       irq_req_i,
   input  logic       bus_req_i,
   input  logic       sleep_cmd_i,
   input  logic       standby_cmd_i,
   output cps_state_e state_o,
   output logic       por_kind_o,
   output pd_mode_e   pd_mode_o,
   output logic       take_evt_o,
   output logic       leave_rst_o
);
   cps_state_e st_q, st_d;
   pd_mode_e   pd_q, pd_d;
   logic       kind_q, kind_d;

   always_comb begin
      st_d   = st_q;
      pd_d   = pd_q;
      kind_d = kind_q;
      if (!mrst_n) begin
         st_d   = CPS_RESET;
         kind_d = 1'b0;
      end else begin
         unique case (st_q)
            CPS_RESET: st_d = CPS_RUN;
            CPS_EXC:   st_d = CPS_RUN;
            CPS_RUN: begin
               if (exc_req_i || irq_req_i) begin
                  st_d = CPS_EXC;
               end else if (bus_req_i) begin
                  st_d = CPS_BUSREL;
               end else if (sleep_cmd_i) begin
                  st_d = CPS_PDOWN;
                  pd_d = PD_SLEEP;
               end else if (standby_cmd_i) begin
                  st_d = CPS_PDOWN;
                  pd_d = PD_STANDBY;
               end
            end
            CPS_PDOWN: begin
               if (pd_q == PD_SLEEP && irq_req_i) st_d = CPS_EXC;
            end
            CPS_BUSREL: begin
               if (!bus_req_i) st_d = CPS_RUN;
            end
            default: st_d = CPS_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q   <= CPS_RESET;
         pd_q   <= PD_SLEEP;
         kind_q <= 1'b1;
      end else begin
         st_q   <= st_d;
         pd_q   <= pd_d;
         kind_q <= kind_d;
      end
   end

   assign take_evt_o  = mrst_n &&
                        ((st_q == CPS_RUN && (exc_req_i || irq_req_i)) ||
                         (st_q == CPS_PDOWN && pd_q == PD_SLEEP && irq_req_i));
   assign leave_rst_o = mrst_n && (st_q == CPS_RESET);
   assign state_o     = st_q;
   assign por_kind_o  = kind_q;
   assign pd_mode_o   = pd_q;

   assert_mrst_scope_R2: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> (st_q == CPS_RESET && !kind_q));
   assert_exc_transient_R6: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == CPS_EXC && mrst_n) |=> (st_q == CPS_RUN));
   assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == CPS_BUSREL && bus_req_i && mrst_n) |=> (st_q == CPS_BUSREL));
   assert_bus_exit_R8: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == CPS_BUSREL && !bus_req_i && mrst_n) |=> (st_q == CPS_RUN));
   assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == CPS_PDOWN && pd_q == PD_SLEEP && !irq_req_i && mrst_n)
      |=> (st_q == CPS_PDOWN));
   assert_standby_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == CPS_PDOWN && pd_q == PD_STANDBY && mrst_n)
      |=> (st_q == CPS_PDOWN && pd_q == PD_STANDBY));
endmodule

// File: rtl/cps_ctx.sv
module cps_ctx #(
   parameter int unsigned        XLEN      = 32,
   parameter int unsigned        SR_W      = 32,
   parameter int unsigned        OFS_W     = 12,
   parameter logic [XLEN-1:0]    RESET_VEC = 32'hA000_0000
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            mrst_n,
   input  logic            take_evt_i,
   input  logic            leave_rst_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [SR_W-1:0] sr_i,
   input  logic [XLEN-1:0] vbr_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic            redir_v_o,
   output logic [XLEN-1:0] redir_addr_o,
   output logic [XLEN-1:0] spc_o,
   output logic [SR_W-1:0] ssr_o
);
   localparam int unsigned PAD_W = XLEN - OFS_W;

   logic [XLEN-1:0] ofs_ext;
   logic [XLEN-1:0] vec_addr;

   generate
      if (PAD_W == 0) begin : g_full_ofs
         assign ofs_ext = ofs_i;
      end else begin : g_pad_ofs
         assign ofs_ext = {{PAD_W{1'b0}}, ofs_i};
      end
   endgenerate

   assign vec_addr = vbr_i + ofs_ext;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         redir_v_o    <= 1'b0;
         redir_addr_o <= '0;
         spc_o        <= '0;
         ssr_o        <= '0;
      end else if (!mrst_n) begin
         redir_v_o    <= 1'b0;
         redir_addr_o <= '0;
         spc_o        <= '0;
         ssr_o        <= '0;
      end else begin
         redir_v_o <= leave_rst_i || take_evt_i;
         if (leave_rst_i) begin
            redir_addr_o <= RESET_VEC;
         end else if (take_evt_i) begin
            redir_addr_o <= vec_addr;
            spc_o        <= pc_i;
            ssr_o        <= sr_i;
         end
      end
   end

   assert_reset_vec_R4: assert property (@(posedge clk) disable iff (!por_n)
      leave_rst_i |=> (redir_v_o && redir_addr_o == RESET_VEC));
   assert_ctx_save_R5: assert property (@(posedge clk) disable iff (!por_n)
      take_evt_i |=> (redir_v_o && spc_o == $past(pc_i) && ssr_o == $past(sr_i)));
   assert_ctx_stable_R11: assert property (@(posedge clk) disable iff (!por_n)
      (!take_evt_i && mrst_n) |=> ($stable(spc_o) && $stable(ssr_o)));
endmodule

// File: rtl/cps_scope.sv
module cps_scope
   import cps_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  cps_state_e state_i,
   input  logic       por_kind_i,
   input  pd_mode_e   pd_mode_i,
   output logic       rst_mod_en_o,
   output logic       rst_busctl_en_o,
   output logic       bus_gnt_o,
   output logic       cpu_run_o,
   output logic       sleep_o,
   output logic       standby_o
);
   always_comb begin
      rst_mod_en_o    = (state_i == CPS_RESET);
      rst_busctl_en_o = (state_i == CPS_RESET) && por_kind_i;
      bus_gnt_o       = (state_i == CPS_BUSREL);
      cpu_run_o       = (state_i == CPS_RUN);
      sleep_o         = (state_i == CPS_PDOWN) && (pd_mode_i == PD_SLEEP);
      standby_o       = (state_i == CPS_PDOWN) && (pd_mode_i == PD_STANDBY);
   end

   assert_busctl_scope_R3: assert property (@(posedge clk) disable iff (!por_n)
      rst_busctl_en_o |-> rst_mod_en_o);
   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({rst_mod_en_o, bus_gnt_o, cpu_run_o, sleep_o, standby_o}));
endmodule

// File: rtl/cpu_state_ctl.sv
module cpu_state_ctl
   import cps_pkg::*;
#(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     SR_W      = 32,
   parameter int unsigned     OFS_W     = 12,
   parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             exc_req_i,
   input  logic             irq_req_i,
   input  logic [OFS_W-1:0] vec_ofs_i,
   input  logic [XLEN-1:0]  vbr_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [SR_W-1:0]  sr_i,
   input  logic             bus_req_i,
   input  logic             sleep_cmd_i,
   input  logic             standby_cmd_i,
   output logic [2:0]       state_o,
   output logic             pc_load_o,
   output logic [XLEN-1:0]  pc_target_o,
   output logic [XLEN-1:0]  spc_o,
   output logic [SR_W-1:0]  ssr_o,
   output logic             bus_gnt_o,
   output logic             cpu_run_o,
   output logic             sleep_o,
   output logic             standby_o,
   output logic             rst_mod_en_o,
   output logic             rst_busctl_en_o
);
   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("cpu_state_ctl: XLEN must be at least 16");
      end
      if (OFS_W < 1 || OFS_W > XLEN) begin : g_bad_ofs
         $error("cpu_state_ctl: OFS_W must lie in 1..XLEN");
      end
      if (SR_W < 1) begin : g_bad_sr
         $error("cpu_state_ctl: SR_W must be positive");
      end
   endgenerate

   cps_state_e st;
   pd_mode_e   pd_mode;
   logic       por_kind;
   logic       take_evt;
   logic       leave_rst;

   cps_seq u_seq (
      .clk           (clk),
      .por_n         (por_n),
      .mrst_n        (mrst_n),
      .exc_req_i     (exc_req_i),
      .irq_req_i     (irq_req_i),
      .bus_req_i     (bus_req_i),
      .sleep_cmd_i   (sleep_cmd_i),
      .standby_cmd_i (standby_cmd_i),
      .state_o       (st),
      .por_kind_o    (por_kind),
      .pd_mode_o     (pd_mode),
      .take_evt_o    (take_evt),
      .leave_rst_o   (leave_rst)
   );

   cps_ctx #(
      .XLEN      (XLEN),
      .SR_W      (SR_W),
      .OFS_W     (OFS_W),
      .RESET_VEC (RESET_VEC)
   ) u_ctx (
      .clk          (clk),
      .por_n        (por_n),
      .mrst_n       (mrst_n),
      .take_evt_i   (take_evt),
      .leave_rst_i  (leave_rst),
      .pc_i         (pc_i),
      .sr_i         (sr_i),
      .vbr_i        (vbr_i),
      .ofs_i        (vec_ofs_i),
      .redir_v_o    (pc_load_o),
      .redir_addr_o (pc_target_o),
      .spc_o        (spc_o),
      .ssr_o        (ssr_o)
   );

   cps_scope u_scope (
      .clk             (clk),
      .por_n           (por_n),
      .state_i         (st),
      .por_kind_i      (por_kind),
      .pd_mode_i       (pd_mode),
      .rst_mod_en_o    (rst_mod_en_o),
      .rst_busctl_en_o (rst_busctl_en_o),
      .bus_gnt_o       (bus_gnt_o),
      .cpu_run_o       (cpu_run_o),
      .sleep_o         (sleep_o),
      .standby_o       (standby_o)
   );

   assign state_o = st;

   assert_redirect_in_exc_R5: assert property (@(posedge clk) disable iff (!por_n)
      (state_o == 3'd1) |-> pc_load_o);
endmodule

// File: tb/cpu_state_ctl_bench.sv
`timescale 1ns/1ps
module cpu_state_ctl_bench;
   localparam int          XLEN  = 32;
   localparam int          SR_W  = 32;
   localparam int          OFS_W = 12;
   localparam logic [31:0] RVEC  = 32'hA000_0000;

   logic             clk = 1'b0;
   logic             por_n = 1'b1;
   logic             mrst_n = 1'b1;
   logic             exc_req = 1'b0;
   logic             irq_req = 1'b0;
   logic [OFS_W-1:0] vec_ofs = '0;
   logic [XLEN-1:0]  vbr = '0;
   logic [XLEN-1:0]  pc = '0;
   logic [SR_W-1:0]  sr = '0;
   logic             bus_req = 1'b0;
   logic             sleep_cmd = 1'b0;
   logic             standby_cmd = 1'b0;
   logic [2:0]       state;
   logic             pc_load;
   logic [XLEN-1:0]  pc_target;
   logic [XLEN-1:0]  spc;
   logic [SR_W-1:0]  ssr;
   logic             bus_gnt, cpu_run, sleep_f, standby_f, rst_mod, rst_busctl;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // bench-side expected state
   int          m_st  = 0;
   bit          m_por = 1'b1;
   bit          m_stb = 1'b0;
   bit          m_rv  = 1'b0;
   logic [31:0] m_ra  = '0;
   logic [31:0] m_spc = '0;
   logic [31:0] m_ssr = '0;

   always #2 clk = ~clk;

   cpu_state_ctl u_cpu_state_ctl (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .exc_req_i(exc_req),
      .irq_req_i(irq_req), .vec_ofs_i(vec_ofs), .vbr_i(vbr), .pc_i(pc),
      .sr_i(sr), .bus_req_i(bus_req), .sleep_cmd_i(sleep_cmd),
      .standby_cmd_i(standby_cmd), .state_o(state), .pc_load_o(pc_load),
      .pc_target_o(pc_target), .spc_o(spc), .ssr_o(ssr), .bus_gnt_o(bus_gnt),
      .cpu_run_o(cpu_run), .sleep_o(sleep_f), .standby_o(standby_f),
      .rst_mod_en_o(rst_mod), .rst_busctl_en_o(rst_busctl)
   );

   function automatic logic [31:0] vec_target(logic [31:0] base, logic [OFS_W-1:0] o);
      return base + {{(32-OFS_W){1'b0}}, o};
   endfunction

   function automatic bit evt_taken(int st, bit stb, bit e, bit i);
      if (st == 2) return e | i;
      if (st == 3 && !stb) return i;
      return 1'b0;
   endfunction

   task automatic model_clk();
      bit rv_n = 1'b0;
      if (!por_n) begin
         m_st = 0; m_por = 1'b1; m_stb = 1'b0;
         m_rv = 1'b0; m_ra = '0; m_spc = '0; m_ssr = '0;
         return;
      end
      if (!mrst_n) begin
         m_st = 0; m_por = 1'b0;
         m_rv = 1'b0; m_ra = '0; m_spc = '0; m_ssr = '0;
         return;
      end
      if (evt_taken(m_st, m_stb, exc_req, irq_req)) begin
         m_st = 1; rv_n = 1'b1; m_ra = vec_target(vbr, vec_ofs);
         m_spc = pc; m_ssr = sr;
      end else begin
         case (m_st)
            0: begin m_st = 2; rv_n = 1'b1; m_ra = RVEC; end
            1: m_st = 2;
            2: begin
               if (bus_req) m_st = 4;
               else if (sleep_cmd) begin m_st = 3; m_stb = 1'b0; end
               else if (standby_cmd) begin m_st = 3; m_stb = 1'b1; end
            end
            4: if (!bus_req) m_st = 2;
            default: ;
         endcase
      end
      m_rv = rv_n;
   endtask

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "state", 32'(state), 32'(m_st));
      chk(tag, "rst_mod_en", 32'(rst_mod), 32'(m_st == 0));
      chk(tag, "rst_busctl_en", 32'(rst_busctl), 32'(m_st == 0 && m_por));
      chk(tag, "bus_gnt", 32'(bus_gnt), 32'(m_st == 4));
      chk(tag, "cpu_run", 32'(cpu_run), 32'(m_st == 2));
      chk(tag, "sleep", 32'(sleep_f), 32'(m_st == 3 && !m_stb));
      chk(tag, "standby", 32'(standby_f), 32'(m_st == 3 && m_stb));
      chk(tag, "pc_load", 32'(pc_load), 32'(m_rv));
      if (m_rv) chk(tag, "pc_target", pc_target, m_ra);
      chk(tag, "spc", spc, m_spc);
      chk(tag, "ssr", ssr, m_ssr);
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_clk();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle();
      exc_req = 0; irq_req = 0; bus_req = 0; sleep_cmd = 0; standby_cmd = 0;
      por_n = 1; mrst_n = 1;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      #1 por_n = 0;
      @(negedge clk);
      compare("R1");
      step("R1");
      mrst_n = 0;
      step("R3");
      step("R3");
      por_n = 1;
      step("R2");
      mrst_n = 1;
      step("R4");
      step("R11");
      // exception entry
      pc = 32'h1234_5678; sr = 32'h0000_00F0; vbr = 32'h8000_1000; vec_ofs = 12'hFFF;
      exc_req = 1;
      step("R5");
      exc_req = 0; irq_req = 1; pc = 32'h0;
      step("R6");
      irq_req = 0;
      // priority
      exc_req = 1; bus_req = 1; sleep_cmd = 1; pc = 32'h0000_0400;
      step("R7");
      exc_req = 0;
      step("R6");
      step("R7");
      sleep_cmd = 0;
      step("R8"); step("R8");
      bus_req = 0;
      step("R8");
      sleep_cmd = 1; standby_cmd = 1;
      step("R7");
      sleep_cmd = 0; standby_cmd = 0;
      exc_req = 1; bus_req = 1;
      step("R9");
      exc_req = 0; bus_req = 0; irq_req = 1; pc = 32'hCAFE_0002; sr = 32'h1; vec_ofs = 12'h600;
      step("R9");
      irq_req = 0;
      step("R6");
      standby_cmd = 1;
      step("R10");
      standby_cmd = 0; irq_req = 1;
      step("R10");
      irq_req = 0; exc_req = 1;
      step("R10");
      exc_req = 0; bus_req = 1; sleep_cmd = 1;
      step("R10");
      idle();
      mrst_n = 0;
      step("R2");
      mrst_n = 1;
      step("R4");
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         por_n       = ($urandom_range(0, 299) != 0);
         mrst_n      = ($urandom_range(0, 119) != 0);
         exc_req     = ($urandom_range(0, 15) == 0);
         irq_req     = ($urandom_range(0, 11) == 0);
         if ($urandom_range(0, 7) == 0) bus_req = ~bus_req;
         sleep_cmd   = ($urandom_range(0, 19) == 0);
         standby_cmd = ($urandom_range(0, 39) == 0);
         pc          = $urandom;
         sr          = $urandom;
         vbr         = $urandom;
         vec_ofs     = OFS_W'($urandom);
         step("R11");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule